// File: doc/BRIEF.md
# Incrementing Block-Copy Bus Sequencer

This block produces the bus activity of a forward block-copy instruction in a processor whose 24-bit addresses are an 8-bit bank joined to a 16-bit offset. A one-cycle start request loads the program counter, the program bank, the source offset, the destination offset and a count that holds the number of bytes minus one. The block then runs a fixed seven-cycle frame for each byte. Each frame fetches the three instruction bytes again: the opcode, then the destination bank, then the source bank. It then reads one source byte, writes that byte to the destination and ends with two internal cycles.

After every frame the source and destination offsets step up by one, wrapping within their banks, and the count steps down by one. The program counter stays on the instruction while bytes remain. When the count wraps from zero to all ones, the block spends one more cycle presenting the next opcode address (PC+3) with a done pulse, and then returns to idle.

The states are ST_IDLE, ST_OPC (opcode fetch), ST_DBK (destination bank fetch), ST_SBK (source bank fetch), ST_SRD (source read), ST_DWR (destination write), ST_IN1 and ST_IN2 (internal cycles) and ST_NEXT (next opcode fetch). The transitions are:
- ST_IDLE to ST_OPC on start.
- ST_OPC to ST_DBK, ST_DBK to ST_SBK, ST_SBK to ST_SRD, ST_SRD to ST_DWR, ST_DWR to ST_IN1 and ST_IN1 to ST_IN2, each unconditionally.
- ST_IN2 to ST_OPC while the count is non-zero, or ST_IN2 to ST_NEXT when it is zero.
- ST_NEXT to ST_IDLE.

Top module: `blkmv_seq`

## Requirements
- R1: After a synchronous reset, and whenever the block is idle, it drives vda=0, vpa=0, rw=1, done=0, busy=0 and addr=0.
- R2: Frame cycle 1 presents {pbank,PC} with vda=1, vpa=1 and rw=1 (the opcode fetch).
- R3: Frame cycles 2 and 3 present {pbank,PC+1} and {pbank,PC+2} (the offset wraps modulo 2^16) with vda=0, vpa=1 and rw=1. The byte read in cycle 2 becomes the destination bank and the byte read in cycle 3 becomes the source bank.
- R4: Frame cycle 4 presents {source bank,X} with vda=1, vpa=0 and rw=1, and captures the byte read.
- R5: Frame cycle 5 presents {destination bank,Y} with vda=1, vpa=0 and rw=0, and wdata carries the byte captured in cycle 4.
- R6: Frame cycles 6 and 7 present {destination bank,Y} with vda=0, vpa=0 and rw=1.
- R7: After each frame X and Y each increase by one modulo 2^16 and the count decreases by one. The next frame starts again at the same PC.
- R8: A loaded count of N produces exactly N+1 frames, and the count reads 16'hFFFF at completion.
- R9: After the last frame, one cycle presents {pbank,PC+3} with vda=1, vpa=1, rw=1, done=1 and next_pc=PC+3. The following cycle is idle.
- R10: vp_n and ml_n are high in every cycle.
- R11: start and the load inputs are ignored while busy is high.
- R12: busy is high from the cycle after start through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin the copy |
| pc_in | input | 16 | Offset of the copy instruction's opcode |
| pbank_in | input | 8 | Program bank |
| x_in | input | 16 | Starting source offset |
| y_in | input | 16 | Starting destination offset |
| cnt_in | input | 16 | Bytes to move minus one |
| rdata | input | 8 | Read data returned for the presented address |
| addr | output | 24 | Bus address, bank in bits 23:16 |
| vda | output | 1 | Valid data address strobe |
| vpa | output | 1 | Valid program address strobe |
| vp_n | output | 1 | Vector pull, active low |
| ml_n | output | 1 | Memory lock, active low |
| rw | output | 1 | 1 = read, 0 = write |
| wdata | output | 8 | Write data, valid while rw=0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Pulse on the cycle PC+3 is presented |
| next_pc | output | 16 | PC+3 of the loaded instruction |
| x_out | output | 16 | Current source offset |
| y_out | output | 16 | Current destination offset |
| cnt_out | output | 16 | Current remaining count |

## Verification
The checks assume that read data is a function of the presented address only, and that start pulses come while the block is idle, apart from deliberate pokes that are expected to be ignored. The assertions rely on the frame order: an opcode fetch is always followed by a program-only fetch, and a write is always preceded by a data read. The stimulus models memory as a pure address function. Its random runs use short counts with arbitrary offsets and banks, and directed cases cover a count of zero, a source offset that wraps and a PC that wraps within its bank. In some runs start is raised with fresh operands in mid-frame.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPC,
        ST_DBK,
        ST_SBK,
        ST_SRD,
        ST_DWR,
        ST_IN1,
        ST_IN2,
        ST_NEXT
    } bm_state_e;

    localparam int unsigned INSN_BYTES = 3;

endpackage

// File: rtl/blkmv_fsm.sv
module blkmv_fsm
    import blkmv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      last_byte,
    output bm_state_e state
);

    bm_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_OPC;
            ST_OPC:  state_nx = ST_DBK;
            ST_DBK:  state_nx = ST_SBK;
            ST_SBK:  state_nx = ST_SRD;
            ST_SRD:  state_nx = ST_DWR;
            ST_DWR:  state_nx = ST_IN1;
            ST_IN1:  state_nx = ST_IN2;
            ST_IN2:  state_nx = last_byte ? ST_NEXT : ST_OPC;
            ST_NEXT: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

endmodule

// File: rtl/blkmv_regs.sv
module blkmv_regs
    import blkmv_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bm_state_e         state,
    input  logic              start,
    input  logic [OFS_W-1:0]  pc_in,
    input  logic [BANK_W-1:0] pbank_in,
    input  logic [OFS_W-1:0]  x_in,
    input  logic [OFS_W-1:0]  y_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [DATA_W-1:0] rdata,
    output logic [OFS_W-1:0]  pc_q,
    output logic [BANK_W-1:0] pbank_q,
    output logic [BANK_W-1:0] sbank_q,
    output logic [BANK_W-1:0] dbank_q,
    output logic [OFS_W-1:0]  x_q,
    output logic [OFS_W-1:0]  y_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [DATA_W-1:0] dbuf_q,
    output logic              last_byte
);

    localparam logic [OFS_W-1:0] OFS_ONE = OFS_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    assign last_byte = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            pbank_q <= '0;
            sbank_q <= '0;
            dbank_q <= '0;
            x_q     <= '0;
            y_q     <= '0;
            cnt_q   <= '0;
            dbuf_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pc_q    <= pc_in;
                        pbank_q <= pbank_in;
                        x_q     <= x_in;
                        y_q     <= y_in;
                        cnt_q   <= cnt_in;
                    end
                end
                ST_DBK: dbank_q <= rdata[BANK_W-1:0];
                ST_SBK: sbank_q <= rdata[BANK_W-1:0];
                ST_SRD: dbuf_q  <= rdata;
                ST_IN2: begin
                    x_q   <= x_q + OFS_ONE;
                    y_q   <= y_q + OFS_ONE;
                    cnt_q <= cnt_q - CNT_ONE;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/blkmv_bus.sv
module blkmv_bus
    import blkmv_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16,
    parameter int DATA_W = 8
) (
    input  bm_state_e                state,
    input  logic [OFS_W-1:0]         pc_q,
    input  logic [BANK_W-1:0]        pbank_q,
    input  logic [BANK_W-1:0]        sbank_q,
    input  logic [BANK_W-1:0]        dbank_q,
    input  logic [OFS_W-1:0]         x_q,
    input  logic [OFS_W-1:0]         y_q,
    input  logic [DATA_W-1:0]        dbuf_q,
    output logic [BANK_W+OFS_W-1:0]  addr,
    output logic                     vda,
    output logic                     vpa,
    output logic                     rw,
    output logic [DATA_W-1:0]        wdata,
    output logic                     busy,
    output logic                     done,
    output logic [OFS_W-1:0]         next_pc
);

    localparam logic [OFS_W-1:0] PC_P1 = OFS_W'(1);
    localparam logic [OFS_W-1:0] PC_P2 = OFS_W'(2);
    localparam logic [OFS_W-1:0] PC_P3 = OFS_W'(INSN_BYTES);

    assign next_pc = pc_q + PC_P3;

    always_comb begin
        addr  = '0;
        vda   = 1'b0;
        vpa   = 1'b0;
        rw    = 1'b1;
        wdata = '0;
        busy  = 1'b1;
        done  = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_OPC: begin
                addr = {pbank_q, pc_q};
                vda  = 1'b1;
                vpa  = 1'b1;
            end
            ST_DBK: begin
                addr = {pbank_q, pc_q + PC_P1};
                vpa  = 1'b1;
            end
            ST_SBK: begin
                addr = {pbank_q, pc_q + PC_P2};
                vpa  = 1'b1;
            end
            ST_SRD: begin
                addr = {sbank_q, x_q};
                vda  = 1'b1;
            end
            ST_DWR: begin
                addr  = {dbank_q, y_q};
                vda   = 1'b1;
                rw    = 1'b0;
                wdata = dbuf_q;
            end
            ST_IN1, ST_IN2: addr = {dbank_q, y_q};
            ST_NEXT: begin
                addr = {pbank_q, next_pc};
                vda  = 1'b1;
                vpa  = 1'b1;
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/blkmv_seq.sv
module blkmv_seq
    import blkmv_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    localparam int ADDR_W = BANK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OFS_W-1:0]  pc_in,
    input  logic [BANK_W-1:0] pbank_in,
    input  logic [OFS_W-1:0]  x_in,
    input  logic [OFS_W-1:0]  y_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic              vda,
    output logic              vpa,
    output logic              vp_n,
    output logic              ml_n,
    output logic              rw,
    output logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [OFS_W-1:0]  next_pc,
    output logic [OFS_W-1:0]  x_out,
    output logic [OFS_W-1:0]  y_out,
    output logic [CNT_W-1:0]  cnt_out
);

    bm_state_e         state;
    logic              last_byte;
    logic [OFS_W-1:0]  pc_q;
    logic [BANK_W-1:0] pbank_q;
    logic [BANK_W-1:0] sbank_q;
    logic [BANK_W-1:0] dbank_q;
    logic [DATA_W-1:0] dbuf_q;

    assign vp_n = 1'b1;
    assign ml_n = 1'b1;

    blkmv_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .last_byte (last_byte),
        .state     (state)
    );

    blkmv_regs #(
        .BANK_W (BANK_W),
        .OFS_W  (OFS_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .start     (start),
        .pc_in     (pc_in),
        .pbank_in  (pbank_in),
        .x_in      (x_in),
        .y_in      (y_in),
        .cnt_in    (cnt_in),
        .rdata     (rdata),
        .pc_q      (pc_q),
        .pbank_q   (pbank_q),
        .sbank_q   (sbank_q),
        .dbank_q   (dbank_q),
        .x_q       (x_out),
        .y_q       (y_out),
        .cnt_q     (cnt_out),
        .dbuf_q    (dbuf_q),
        .last_byte (last_byte)
    );

    blkmv_bus #(
        .BANK_W (BANK_W),
        .OFS_W  (OFS_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .state   (state),
        .pc_q    (pc_q),
        .pbank_q (pbank_q),
        .sbank_q (sbank_q),
        .dbank_q (dbank_q),
        .x_q     (x_out),
        .y_q     (y_out),
        .dbuf_q  (dbuf_q),
        .addr    (addr),
        .vda     (vda),
        .vpa     (vpa),
        .rw      (rw),
        .wdata   (wdata),
        .busy    (busy),
        .done    (done),
        .next_pc (next_pc)
    );

endmodule

// File: rtl/blkmv_chk.sv
module blkmv_chk #(
    parameter int OFS_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             vda,
    input logic             vpa,
    input logic             rw,
    input logic [OFS_W-1:0] x_out
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!vda && !vpa && rw && !done)); // R1

    AST_SYNC_THEN_PROG: assert property (@(posedge clk) disable iff (rst)
        (vda && vpa && !done) |=> (!vda && vpa && rw)); // R3

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        !rw |-> ($past(vda && !vpa && rw) && vda && !vpa)); // R5

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && !done)); // R9

    AST_SRC_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (x_out != $past(x_out)))
            |-> (x_out == OFS_W'($past(x_out) + 1'b1))); // R7

    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R12

endmodule

bind blkmv_seq blkmv_chk #(.OFS_W(OFS_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .busy  (busy),
    .done  (done),
    .vda   (vda),
    .vpa   (vpa),
    .rw    (rw),
    .x_out (x_out)
);

// File: tb/blkmv_seq_tb.sv
`timescale 1ns/1ps
module blkmv_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  pbank_in = '0;
    logic [15:0] x_in = '0;
    logic [15:0] y_in = '0;
    logic [15:0] cnt_in = '0;
    logic [7:0]  rdata;
    logic [23:0] addr;
    logic        vda, vpa, vp_n, ml_n, rw, busy, done;
    logic [7:0]  wdata;
    logic [15:0] next_pc, x_out, y_out, cnt_out;

    int checks = 0;
    int failures = 0;

    // memory model: instruction operands at PC+1/PC+2, otherwise a pure address hash
    logic [7:0]  m_pb, m_dbk, m_sbk;
    logic [15:0] m_pc;

    function automatic logic [7:0] hash8(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    assign rdata = (addr == {m_pb, m_pc + 16'd1}) ? m_dbk :
                   (addr == {m_pb, m_pc + 16'd2}) ? m_sbk :
                   (addr[7:0] ^ addr[15:8] ^ addr[23:16] ^ 8'h5A);

    always #2 clk = ~clk;

    blkmv_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .pc_in(pc_in), .pbank_in(pbank_in),
        .x_in(x_in), .y_in(y_in), .cnt_in(cnt_in), .rdata(rdata), .addr(addr),
        .vda(vda), .vpa(vpa), .vp_n(vp_n), .ml_n(ml_n), .rw(rw), .wdata(wdata),
        .busy(busy), .done(done), .next_pc(next_pc), .x_out(x_out),
        .y_out(y_out), .cnt_out(cnt_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // bus vector: addr, vda, vpa, rw, done, busy, vp_n, ml_n
    task automatic expect_cyc(input string req, input logic [23:0] ea,
                              input bit evda, input bit evpa, input bit erw, input bit edone);
        logic [30:0] act, exp;
        act = {addr, vda, vpa, rw, done, busy, vp_n, ml_n};
        exp = {ea, evda, evpa, erw, edone, 1'b1, 1'b1, 1'b1};
        chk(act === exp, req, "bus", 64'(act), 64'(exp));
    endtask

    task automatic run_op(input logic [15:0] pc, input logic [7:0] pb,
                          input logic [15:0] x, input logic [15:0] y,
                          input logic [15:0] n, input logic [7:0] dbk,
                          input logic [7:0] sbk, input bit poke);
        logic [15:0] cx, cy;
        logic [7:0]  byte_exp;
        m_pb = pb; m_pc = pc; m_dbk = dbk; m_sbk = sbk;
        pc_in = pc; pbank_in = pb; x_in = x; y_in = y; cnt_in = n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cx = x; cy = y;
        for (int f = 0; f <= int'(n); f++) begin
            expect_cyc("R2", {pb, pc}, 1, 1, 1, 0);
            chk(vp_n && ml_n, "R10", "vp_n/ml_n", {62'd0, vp_n, ml_n}, 64'd3);
            chk(busy, "R12", "busy", 64'(busy), 64'd1);
            @(negedge clk);
            expect_cyc("R3", {pb, pc + 16'd1}, 0, 1, 1, 0);
            @(negedge clk);
            expect_cyc("R3", {pb, pc + 16'd2}, 0, 1, 1, 0);
            if (poke) begin
                start = 1'b1; x_in = 16'($urandom); cnt_in = 16'hFFFF;
            end
            @(negedge clk);
            start = 1'b0;
            expect_cyc("R4", {sbk, cx}, 1, 0, 1, 0);
            byte_exp = hash8({sbk, cx});
            if ({sbk, cx} == {pb, pc + 16'd1}) byte_exp = dbk;
            if ({sbk, cx} == {pb, pc + 16'd2}) byte_exp = sbk;
            @(negedge clk);
            expect_cyc(poke ? "R11" : "R5", {dbk, cy}, 1, 0, 0, 0);
            chk(wdata === byte_exp, "R5", "wdata", 64'(wdata), 64'(byte_exp));
            @(negedge clk);
            expect_cyc("R6", {dbk, cy}, 0, 0, 1, 0);
            @(negedge clk);
            expect_cyc("R6", {dbk, cy}, 0, 0, 1, 0);
            chk(cnt_out === 16'(n - 16'(f)), "R7", "count mid", 64'(cnt_out), 64'(n - 16'(f)));
            @(negedge clk);
            cx = cx + 16'd1; cy = cy + 16'd1;
            chk({x_out, y_out} === {cx, cy}, "R7", "x/y step", {32'd0, x_out, y_out}, {32'd0, cx, cy});
        end
        expect_cyc("R9", {pb, pc + 16'd3}, 1, 1, 1, 1);
        chk(next_pc === pc + 16'd3, "R9", "next_pc", 64'(next_pc), 64'(pc + 16'd3));
        chk(cnt_out === 16'hFFFF, "R8", "final count", 64'(cnt_out), 64'hFFFF);
        @(negedge clk);
        chk({busy, done, vda, vpa, rw} === 5'b00001, "R9", "idle after done",
            64'({busy, done, vda, vpa, rw}), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd20240607));
        m_pb = 8'h00; m_pc = 16'h0000; m_dbk = 8'h00; m_sbk = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, vda, vpa, rw, vp_n, ml_n} === 7'b0000111, "R1", "reset outputs",
            64'({busy, done, vda, vpa, rw, vp_n, ml_n}), 64'h07);
        chk(addr === 24'd0, "R1", "idle addr", 64'(addr), 64'd0);

        // directed: single byte (count 0)
        run_op(16'h1000, 8'h02, 16'h0040, 16'h8000, 16'h0000, 8'h7E, 8'h03, 1'b0);
        // directed: source offset wraps within bank
        run_op(16'h2000, 8'h01, 16'hFFFF, 16'h0010, 16'h0002, 8'h11, 8'h22, 1'b0);
        // directed: PC+1..PC+3 wrap within the program bank
        run_op(16'hFFFE, 8'h05, 16'h0100, 16'h0200, 16'h0001, 8'h33, 8'h44, 1'b0);
        // directed: start poked mid-frame is ignored
        run_op(16'h3000, 8'h00, 16'h1234, 16'h4321, 16'h0001, 8'h09, 8'h0A, 1'b1);

        for (int i = 0; i < 20; i++) begin
            run_op(16'($urandom), 8'($urandom), 16'($urandom), 16'($urandom),
                   16'($urandom_range(0, 5)), 8'($urandom), 8'($urandom),
                   bit'($urandom_range(0, 1)));
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end

        // reset in mid-operation returns to idle
        pc_in = 16'h0500; pbank_in = 8'h01; cnt_in = 16'h0003;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk({busy, vda, vpa, rw} === 4'b0001, "R1", "reset mid-op",
            64'({busy, vda, vpa, rw}), 64'd1);
        summary();
    end

endmodule